// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits beside a small DSP-style processor core and decides which interrupt the core services next. Hardware request lines set bits in a pending-flag register. A per-source enable mask and a single global disable bit filter the maskable sources. A fixed rank table then picks one winner. The controller turns the winning interrupt number into a 16-bit vector address. The address is formed from a relocatable 9-bit table pointer and the number scaled by the 4-word slot size, so the whole table covers 0x80 words.

The core can also issue software interrupts that name a number directly. There are three kinds: an ordinary software interrupt, a trap that leaves the global disable bit alone, and a software reset. The controller holds the chosen vector with a valid flag until the core pulses acknowledge. On acknowledge it clears the serviced flag and, except for a trap, sets the global disable bit. Stacking the return address, fetching from the table and running the handler are left to the core.

Top module: `intc_top`

## Requirements
- R1: A high level on `irq_i[n]` at a clock edge sets pending flag n at that edge, whether or not it is enabled. The flag then stays set until it is acknowledged or cleared by a write.
- R2: The vector address is {table pointer[8:0], number[4:0], 2'b00}. A hardware request is presented (`vec_valid_o` high) at the second clock edge after the edge that sampled it. A software request is presented at the first edge after it is sampled.
- R3: Synchronous reset (`rst` high) leaves no vector presented and all flags and mask bits at 0. It sets the global disable bit to 1 and the table pointer to 0x1FF, which places the table at 0xFF80.
- R4: A maskable source (numbers 2..31) is presented only while its mask bit is 1 and the global disable bit is 0. A blocked source keeps its flag.
- R5: Number 0 outranks number 1, and both outrank every maskable source. Both ignore the mask and the global disable bit. Among maskable sources, the one with the lowest rank wins, where the rank of number n is n XOR 16.
- R6: While a vector is presented and not yet acknowledged, its number and address stay fixed. New hardware requests, software requests and pointer writes do not change it, and a software request arriving in that window is dropped.
- R7: `ack_i` high while a vector is presented removes the vector at that edge. It clears that number's flag and sets the global disable bit, except for a trap. No new vector appears at that same edge, so `vec_valid_o` is low for at least one cycle after each acknowledge.
- R8: A software interrupt (`sw_valid_i` with `sw_op_i`=0) presents `sw_num_i` regardless of the mask, the global disable bit and the flags. It takes precedence over pending hardware requests, and on acknowledge it clears that flag and sets global disable.
- R9: A software trap (`sw_op_i`=1) behaves like R8, except that acknowledging it leaves the global disable bit unchanged.
- R10: A software reset (`sw_op_i`=2) presents number 0 using the current pointer. Its acknowledge sets global disable, and the table pointer is not reloaded.
- R11: Register writes take effect at the `wr_en_i` edge, selected by `wr_sel_i`: 0 loads the mask from `wr_data_i`, 1 clears every flag whose data bit is 1, 2 loads global disable from bit 0, and 3 loads the pointer from bits 8:0.
- R12: If a flag-clear write and a new request on the same line occur at the same edge, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_i | input | 32 | Hardware request lines, one per interrupt number |
| sw_valid_i | input | 1 | Software request strobe |
| sw_op_i | input | 2 | Software request kind: 0 interrupt, 1 trap, 2 reset |
| sw_num_i | input | 5 | Interrupt number of a software interrupt or trap |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select: 0 mask, 1 flag clear, 2 global disable, 3 pointer |
| wr_data_i | input | 32 | Register write data |
| ack_i | input | 1 | Core acknowledge of the presented vector |
| vec_valid_o | output | 1 | A vector is presented |
| vec_addr_o | output | 16 | Vector address of the presented interrupt |
| vec_num_o | output | 5 | Number of the presented interrupt |
| flags_o | output | 32 | Pending flags |
| mask_o | output | 32 | Enable mask |
| gdis_o | output | 1 | Global disable bit |
| ptr_o | output | 9 | Vector table pointer |

## Verification
A corrupted flag register shows on `flags_o` at the edge after the bad update. It also shows as a missing or extra vector two edges after a request. A wrong rank compare or a wrong mask gate presents the wrong number on the very next edge, and the sweep over every pair of maskable numbers catches this. A global disable bit left in the wrong state after an acknowledge is visible on `gdis_o` one cycle later. It then shows as a vector that appears or fails to appear on the following edge. A pointer that is wrong or drifts shows in bits 15:7 of the next presented address.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int NUM_IRQ  = 32;
    localparam int NUM_W    = $clog2(NUM_IRQ);
    localparam int PTR_W    = 9;
    localparam int SLOT_SH  = 2;
    localparam int ADDR_W   = PTR_W + NUM_W + SLOT_SH;
    localparam int FIRST_MASKABLE = 2;

    typedef logic [NUM_W-1:0]  num_t;
    typedef logic [PTR_W-1:0]  ptr_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [NUM_IRQ-1:0][NUM_W-1:0] rank_tbl_t;

    typedef enum logic [1:0] {
        SRC_HW     = 2'd0,
        SRC_INTR   = 2'd1,
        SRC_TRAP   = 2'd2,
        SRC_SRESET = 2'd3
    } src_e;

    localparam logic [1:0] SWOP_INTR  = 2'd0;
    localparam logic [1:0] SWOP_TRAP  = 2'd1;
    localparam logic [1:0] SWOP_RESET = 2'd2;

    localparam logic [1:0] SEL_MASK    = 2'd0;
    localparam logic [1:0] SEL_FLAGCLR = 2'd1;
    localparam logic [1:0] SEL_GDIS    = 2'd2;
    localparam logic [1:0] SEL_PTR     = 2'd3;

    typedef struct packed {
        logic  valid;
        src_e  src;
        num_t  num;
        addr_t addr;
    } vec_t;

    function automatic addr_t make_vec_addr(ptr_t ptr, num_t n);
        return {ptr, n, {SLOT_SH{1'b0}}};
    endfunction

    function automatic rank_tbl_t default_ranks();
        rank_tbl_t r;
        for (int i = 0; i < NUM_IRQ; i++) begin
            r[i] = num_t'(i) ^ num_t'(NUM_IRQ / 2);
        end
        return r;
    endfunction

endpackage

// File: rtl/intc_flags.sv
module intc_flags
    import intc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_IRQ-1:0] irq_i,
    input  logic               clr_we_i,
    input  logic [NUM_IRQ-1:0] clr_bits_i,
    input  logic               ack_clr_i,
    input  num_t               ack_num_i,
    output logic [NUM_IRQ-1:0] flag_q
);

    logic [NUM_IRQ-1:0] flag_d;

    always_comb begin
        flag_d = flag_q;
        if (clr_we_i) begin
            flag_d = flag_d & ~clr_bits_i;
        end
        if (ack_clr_i) begin
            flag_d[ack_num_i] = 1'b0;
        end
        flag_d = flag_d | irq_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= '0;
        end else begin
            flag_q <= flag_d;
        end
    end

    // R1: every sampled request shows in the flags one edge later
    p_flag_set_r1: assert property (@(posedge clk) disable iff (rst)
        (|irq_i) |=> ((flag_q & $past(irq_i)) == $past(irq_i)));

    // R7: acknowledge clears the serviced flag unless it is re-raised
    p_ack_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (ack_clr_i && !irq_i[ack_num_i]) |=> !flag_q[$past(ack_num_i)]);

endmodule

// File: rtl/intc_regs.sv
module intc_regs
    import intc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en_i,
    input  logic [1:0]         wr_sel_i,
    input  logic [NUM_IRQ-1:0] wr_data_i,
    input  logic               gdis_set_i,
    output logic [NUM_IRQ-1:0] mask_q,
    output logic               gdis_q,
    output ptr_t               ptr_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            gdis_q <= 1'b1;
            ptr_q  <= '1;
        end else begin
            if (wr_en_i && wr_sel_i == SEL_MASK) begin
                mask_q <= wr_data_i;
            end
            if (wr_en_i && wr_sel_i == SEL_PTR) begin
                ptr_q <= wr_data_i[PTR_W-1:0];
            end
            if (gdis_set_i) begin
                gdis_q <= 1'b1;
            end else if (wr_en_i && wr_sel_i == SEL_GDIS) begin
                gdis_q <= wr_data_i[0];
            end
        end
    end

    // R3: leaving reset, the pointer sits at the top of memory
    p_ptr_reset_r3: assert property (@(posedge clk)
        $fell(rst) |-> (ptr_q == '1 && gdis_q && mask_q == '0));

    // R7: a taken interrupt leaves global disable set
    p_gdis_set_r7: assert property (@(posedge clk) disable iff (rst)
        gdis_set_i |=> gdis_q);

endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
    import intc_pkg::*;
#(
    parameter rank_tbl_t RANKS = default_ranks()
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_IRQ-1:0] flags_i,
    input  logic [NUM_IRQ-1:0] mask_i,
    input  logic               gdis_i,
    output logic               hit_o,
    output num_t               win_num_o,
    output logic [NUM_IRQ-1:0] grant_o
);

    logic [NUM_IRQ-1:0] elig;
    num_t               best_rank;
    logic               found;

    always_comb begin
        elig = flags_i & mask_i & {NUM_IRQ{~gdis_i}};
        elig[FIRST_MASKABLE-1:0] = flags_i[FIRST_MASKABLE-1:0];
    end

    always_comb begin
        found     = 1'b0;
        best_rank = '1;
        win_num_o = '0;
        for (int i = FIRST_MASKABLE; i < NUM_IRQ; i++) begin
            if (elig[i] && (!found || RANKS[i] < best_rank)) begin
                found     = 1'b1;
                best_rank = RANKS[i];
                win_num_o = num_t'(i);
            end
        end
        if (elig[1]) begin
            win_num_o = num_t'(1);
        end
        if (elig[0]) begin
            win_num_o = num_t'(0);
        end
    end

    assign hit_o   = |elig;
    assign grant_o = hit_o ? (NUM_IRQ'(1) << win_num_o) : '0;

    // R4: a maskable grant needs its enable bit and global disable clear
    p_mask_gate_r4: assert property (@(posedge clk) disable iff (rst)
        !(|(grant_o[NUM_IRQ-1:FIRST_MASKABLE] &
            ~(mask_i[NUM_IRQ-1:FIRST_MASKABLE] &
              {(NUM_IRQ-FIRST_MASKABLE){~gdis_i}}))));

    // R5: at most one winner, and a pending number 0 always wins
    p_onehot_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_o));
    p_top_prio_r5: assert property (@(posedge clk) disable iff (rst)
        flags_i[0] |-> grant_o[0]);

endmodule

// File: rtl/intc_top.sv
module intc_top
    import intc_pkg::*;
#(
    parameter rank_tbl_t RANKS = default_ranks()
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [31:0]        irq_i,
    input  logic               sw_valid_i,
    input  logic [1:0]         sw_op_i,
    input  logic [4:0]         sw_num_i,
    input  logic               wr_en_i,
    input  logic [1:0]         wr_sel_i,
    input  logic [31:0]        wr_data_i,
    input  logic               ack_i,
    output logic               vec_valid_o,
    output logic [15:0]        vec_addr_o,
    output logic [4:0]         vec_num_o,
    output logic [31:0]        flags_o,
    output logic [31:0]        mask_o,
    output logic               gdis_o,
    output logic [8:0]         ptr_o
);

    vec_t               vec_q;
    logic [NUM_IRQ-1:0] flag_q;
    logic [NUM_IRQ-1:0] mask_q;
    logic               gdis_q;
    ptr_t               ptr_q;
    logic               hit;
    num_t               win_num;
    logic [NUM_IRQ-1:0] grant;
    logic               ack_take;
    logic               gdis_set;
    logic               sw_take;
    num_t               sw_eff_num;
    src_e               sw_src;

    assign ack_take = ack_i && vec_q.valid;
    assign gdis_set = ack_take && (vec_q.src != SRC_TRAP);
    assign sw_take  = sw_valid_i && (sw_op_i != 2'd3);

    always_comb begin
        unique case (sw_op_i)
            SWOP_TRAP:  begin sw_src = SRC_TRAP;   sw_eff_num = sw_num_i; end
            SWOP_RESET: begin sw_src = SRC_SRESET; sw_eff_num = '0;       end
            default:    begin sw_src = SRC_INTR;   sw_eff_num = sw_num_i; end
        endcase
    end

    intc_flags u_flags (
        .clk        (clk),
        .rst        (rst),
        .irq_i      (irq_i),
        .clr_we_i   (wr_en_i && wr_sel_i == SEL_FLAGCLR),
        .clr_bits_i (wr_data_i),
        .ack_clr_i  (ack_take),
        .ack_num_i  (vec_q.num),
        .flag_q     (flag_q)
    );

    intc_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en_i    (wr_en_i),
        .wr_sel_i   (wr_sel_i),
        .wr_data_i  (wr_data_i),
        .gdis_set_i (gdis_set),
        .mask_q     (mask_q),
        .gdis_q     (gdis_q),
        .ptr_q      (ptr_q)
    );

    intc_arbiter #(.RANKS(RANKS)) u_arb (
        .clk       (clk),
        .rst       (rst),
        .flags_i   (flag_q),
        .mask_i    (mask_q),
        .gdis_i    (gdis_q),
        .hit_o     (hit),
        .win_num_o (win_num),
        .grant_o   (grant)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_q <= '0;
        end else if (ack_take) begin
            vec_q.valid <= 1'b0;
        end else if (!vec_q.valid) begin
            if (sw_take) begin
                vec_q.valid <= 1'b1;
                vec_q.src   <= sw_src;
                vec_q.num   <= sw_eff_num;
                vec_q.addr  <= make_vec_addr(ptr_q, sw_eff_num);
            end else if (hit) begin
                vec_q.valid <= 1'b1;
                vec_q.src   <= SRC_HW;
                vec_q.num   <= win_num;
                vec_q.addr  <= make_vec_addr(ptr_q, win_num);
            end
        end
    end

    assign vec_valid_o = vec_q.valid;
    assign vec_addr_o  = vec_q.addr;
    assign vec_num_o   = vec_q.num;
    assign flags_o     = flag_q;
    assign mask_o      = mask_q;
    assign gdis_o      = gdis_q;
    assign ptr_o       = ptr_q;

    // R6: an unacknowledged vector does not move
    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (vec_q.valid && !ack_i) |=>
            (vec_q.valid && $stable(vec_q.addr) && $stable(vec_q.num)));

    // R7: one vector per acknowledge
    p_one_per_ack_r7: assert property (@(posedge clk) disable iff (rst)
        ack_take |=> !vec_q.valid);

    // R9: acknowledging a trap keeps global disable as it was
    p_trap_keep_r9: assert property (@(posedge clk) disable iff (rst)
        (ack_take && vec_q.src == SRC_TRAP &&
         !(wr_en_i && wr_sel_i == SEL_GDIS)) |=> (gdis_q == $past(gdis_q)));

endmodule

// File: tb/intc_top_tb.sv
module intc_top_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] irq_i = '0;
    logic        sw_valid_i = 1'b0;
    logic [1:0]  sw_op_i = 2'd0;
    logic [4:0]  sw_num_i = '0;
    logic        wr_en_i = 1'b0;
    logic [1:0]  wr_sel_i = 2'd0;
    logic [31:0] wr_data_i = '0;
    logic        ack_i = 1'b0;
    logic        vec_valid_o;
    logic [15:0] vec_addr_o;
    logic [4:0]  vec_num_o;
    logic [31:0] flags_o;
    logic [31:0] mask_o;
    logic        gdis_o;
    logic [8:0]  ptr_o;

    int total = 0;
    int bad   = 0;
    logic finished = 1'b0;

    always #5 clk = ~clk;

    intc_top u_dut (
        .clk(clk), .rst(rst), .irq_i(irq_i),
        .sw_valid_i(sw_valid_i), .sw_op_i(sw_op_i), .sw_num_i(sw_num_i),
        .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
        .ack_i(ack_i), .vec_valid_o(vec_valid_o), .vec_addr_o(vec_addr_o),
        .vec_num_o(vec_num_o), .flags_o(flags_o), .mask_o(mask_o),
        .gdis_o(gdis_o), .ptr_o(ptr_o)
    );

    function automatic logic [15:0] exp_addr(logic [8:0] p, logic [4:0] n);
        return {p, n, 2'b00};
    endfunction

    function automatic logic [4:0] rank_of(int n);
        return 5'(n) ^ 5'd16;
    endfunction

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h at %0t", req, got, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic pulse_irq(logic [31:0] m);
        irq_i = m; step(); irq_i = '0;
    endtask

    task automatic wreg(logic [1:0] sel, logic [31:0] d);
        wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
        step();
        wr_en_i = 1'b0; wr_data_i = '0;
    endtask

    task automatic do_ack();
        ack_i = 1'b1; step(); ack_i = 1'b0;
    endtask

    task automatic sw_req(logic [1:0] op, logic [4:0] n);
        sw_valid_i = 1'b1; sw_op_i = op; sw_num_i = n;
        step();
        sw_valid_i = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1; step(); step(); rst = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog got=hung exp=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        step();
        do_reset();
        // R3 reset state
        chk("R3 valid", 32'(vec_valid_o), 0);
        chk("R3 ptr", 32'(ptr_o), 32'h1FF);
        chk("R3 gdis", 32'(gdis_o), 1);
        chk("R3 mask", mask_o, 0);
        chk("R3 flags", flags_o, 0);

        // R2 address format and latency over several pointers and all maskable numbers
        wreg(2'd0, '1);
        foreach (ptr_list[k]) begin end
        for (int pi = 0; pi < 5; pi++) begin
            logic [8:0] p;
            p = (pi == 0) ? 9'h1FF : (pi == 1) ? 9'h001 : (pi == 2) ? 9'h0AA :
                (pi == 3) ? 9'h155 : 9'h000;
            wreg(2'd3, 32'(p));
            for (int n = 2; n < 32; n++) begin
                wreg(2'd2, 0);
                pulse_irq(32'd1 << n);
                chk("R2 latency", 32'(vec_valid_o), 0);
                chk("R1 flag set", 32'(flags_o[n]), 1);
                step();
                chk("R2 valid", 32'(vec_valid_o), 1);
                chk("R2 num", 32'(vec_num_o), 32'(n));
                chk("R2 addr", 32'(vec_addr_o), 32'(exp_addr(p, 5'(n))));
                do_ack();
                chk("R7 valid low", 32'(vec_valid_o), 0);
                chk("R7 flag clr", 32'(flags_o[n]), 0);
                chk("R7 gdis set", 32'(gdis_o), 1);
            end
        end
        chk("R2 sanity 0x10", 32'(exp_addr(9'h001, 5'h10)), 32'h00C0);

        // R5 every pair of maskable numbers
        wreg(2'd3, 32'h000);
        for (int a = 2; a < 32; a++) begin
            for (int b = a + 1; b < 32; b++) begin
                int w, l;
                w = (rank_of(a) < rank_of(b)) ? a : b;
                l = (w == a) ? b : a;
                wreg(2'd2, 0);
                pulse_irq((32'd1 << a) | (32'd1 << b));
                step();
                chk("R5 pair winner", 32'(vec_num_o), 32'(w));
                do_ack();
                chk("R7 one per ack", 32'(vec_valid_o), 0);
                wreg(2'd2, 0);
                step();
                chk("R5 pair loser", 32'(vec_num_o), 32'(l));
                do_ack();
            end
        end

        // R4 mask gating; R1 flag held while blocked
        wreg(2'd0, 0);
        wreg(2'd2, 0);
        pulse_irq(32'd1 << 20);
        step(); step(); step();
        chk("R4 masked no vec", 32'(vec_valid_o), 0);
        chk("R1 masked flag kept", 32'(flags_o[20]), 1);
        wreg(2'd0, 32'd1 << 20);
        chk("R11 mask write", mask_o, 32'd1 << 20);
        step();
        chk("R4 enabled vec", 32'(vec_num_o), 20);
        do_ack();
        // R4 global disable gating
        wreg(2'd0, '1);
        pulse_irq(32'd1 << 5);
        step(); step();
        chk("R4 gdis blocks", 32'(vec_valid_o), 0);
        wreg(2'd2, 0);
        chk("R11 gdis write", 32'(gdis_o), 0);
        step();
        chk("R4 gdis released", 32'(vec_num_o), 5);
        do_ack();

        // R5 non-maskable ignore mask and gdis, 0 before 1
        wreg(2'd0, 0);
        wreg(2'd3, 32'h0F0);
        pulse_irq(32'h3 | (32'd1 << 9));
        step();
        chk("R5 reset first", 32'(vec_num_o), 0);
        chk("R5 reset addr", 32'(vec_addr_o), 32'(exp_addr(9'h0F0, 5'd0)));
        do_ack();
        chk("R7 gap after ack", 32'(vec_valid_o), 0);
        step();
        chk("R5 nmi next", 32'(vec_num_o), 1);
        do_ack();
        step();
        chk("R4 masked stays", 32'(vec_valid_o), 0);
        wreg(2'd1, 32'd1 << 9);
        chk("R11 flag clear", flags_o, 0);
        // R5 nmi beats maskable
        wreg(2'd0, '1);
        wreg(2'd2, 0);
        pulse_irq(32'h2 | (32'd1 << 16));
        step();
        chk("R5 nmi over maskable", 32'(vec_num_o), 1);
        do_ack();
        wreg(2'd2, 0);
        step();
        chk("R5 maskable after nmi", 32'(vec_num_o), 16);
        do_ack();

        // R8 software interrupt
        wreg(2'd0, 0);
        wreg(2'd2, 0);
        pulse_irq(32'd1 << 7);
        sw_req(2'd0, 5'd7);
        chk("R8 sw valid", 32'(vec_valid_o), 1);
        chk("R8 sw num", 32'(vec_num_o), 7);
        chk("R8 sw addr", 32'(vec_addr_o), 32'(exp_addr(9'h0F0, 5'd7)));
        do_ack();
        chk("R8 sw flag clr", 32'(flags_o[7]), 0);
        chk("R8 sw gdis", 32'(gdis_o), 1);
        sw_req(2'd0, 5'd25);
        chk("R8 sw with gdis", 32'(vec_num_o), 25);
        do_ack();

        // R9 trap
        wreg(2'd2, 0);
        pulse_irq(32'd1 << 12);
        sw_req(2'd1, 5'd12);
        chk("R9 trap num", 32'(vec_num_o), 12);
        do_ack();
        chk("R9 trap gdis kept", 32'(gdis_o), 0);
        chk("R9 trap flag clr", 32'(flags_o[12]), 0);

        // R10 software reset keeps pointer
        wreg(2'd3, 32'h055);
        chk("R11 ptr write", 32'(ptr_o), 32'h055);
        sw_req(2'd2, 5'd13);
        chk("R10 num", 32'(vec_num_o), 0);
        chk("R10 addr", 32'(vec_addr_o), 32'h2A80);
        do_ack();
        chk("R10 gdis", 32'(gdis_o), 1);
        chk("R10 ptr kept", 32'(ptr_o), 32'h055);
        do_reset();
        chk("R3 ptr reload", 32'(ptr_o), 32'h1FF);

        // R6 hold while outstanding
        wreg(2'd0, '1);
        wreg(2'd2, 0);
        wreg(2'd3, 32'h0AA);
        pulse_irq(32'd1 << 30);
        step();
        chk("R6 first num", 32'(vec_num_o), 30);
        wreg(2'd3, 32'h100);
        pulse_irq(32'h1);
        sw_req(2'd0, 5'd3);
        step();
        chk("R6 num held", 32'(vec_num_o), 30);
        chk("R6 addr held", 32'(vec_addr_o), 32'(exp_addr(9'h0AA, 5'd30)));
        do_ack();
        chk("R7 low after ack", 32'(vec_valid_o), 0);
        step();
        chk("R6 queued reset", 32'(vec_num_o), 0);
        chk("R6 new ptr used", 32'(vec_addr_o), 32'(exp_addr(9'h100, 5'd0)));
        do_ack();
        step(); step();
        chk("R6 sw dropped", 32'(vec_valid_o), 0);

        // R12 clear-vs-set collision
        wreg(2'd0, 0);
        irq_i = 32'd1 << 22;
        wreg(2'd1, 32'd1 << 22);
        irq_i = '0;
        chk("R12 set wins", 32'(flags_o[22]), 1);
        wreg(2'd1, 32'd1 << 22);
        chk("R12 later clear", 32'(flags_o[22]), 0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    logic [8:0] ptr_list [1];

endmodule